// File: doc/BRIEF.md
# Two-Input Fuzzy Rule Table

This block is the inference stage of a two-channel fuzzy motor controller. It receives two fuzzified inputs, each a one-hot choice among seven linguistic labels: an error term (the speed gap between the two motors) and the rate at which that error is changing. Every pairing of an error label with a rate label is a rule, so there are 49 rules. All of them are evaluated at once as AND terms. Each rule names one output label for the left channel and one for the right channel, and the block reports the chosen label on each channel as a one-hot vector.

The consequents come from two constant tables given as parameters, one table per channel. The default tables steer the error toward the zero label, so that both motors settle at a common speed whatever that speed is. The result appears two clock cycles after the inputs, and a valid flag travels through the pipeline beside the data. A new input pair may be presented on every cycle.

Label code k stands for one-hot bit k. Code 0 is negative large, code 3 is zero and code 6 is positive large.

Top module: `fuzzy_rule_table`

## Requirements
- R1: While rst_n is low, out_valid is 0 and left_lbl and right_lbl are all zeros.
- R2: out_valid equals the in_valid value applied two clock cycles earlier.
- R3: When err_lbl has only bit i set and rate_lbl has only bit j set, left_lbl two cycles later has only bit c set, where c is the 3-bit code at LEFT_RULES[(i*7+j)*3 +: 3].
- R4: Under the same one-hot input conditions, right_lbl two cycles later has only bit c set, where c is the code at RIGHT_RULES[(i*7+j)*3 +: 3].
- R5: When either err_lbl or rate_lbl does not have exactly one bit set (zero bits or two or more bits), both left_lbl and right_lbl are all zeros two cycles later.
- R6: left_lbl and right_lbl never have more than one bit set.
- R7: With the default tables, let s = (i-3)+(j-3). The left code is 3-s and the right code is 3+s, each clamped to the range 0..6.
- R8: The label outputs follow the input labels whatever the value of in_valid. A different input pair on every cycle gives independent results on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the input pair as meaningful |
| err_lbl | input | 7 | One-hot error label |
| rate_lbl | input | 7 | One-hot error-rate label |
| out_valid | output | 1 | in_valid delayed by two cycles |
| left_lbl | output | 7 | One-hot left motor label, or zero for an invalid input |
| right_lbl | output | 7 | One-hot right motor label, or zero for an invalid input |

## Verification
The bench builds the block with the default parameters: seven labels and the default clamped-sum tables for both channels. With these values, all 49 one-hot label pairs can be checked against the closed-form rule. Both clamp corners are reached, since extreme pairs saturate at codes 0 and 6, and the pairs along the anti-diagonal all land on the zero label. The same build also covers streamed back-to-back inputs, a toggling valid flag, and all-zero and multi-bit input patterns that must blank both outputs.

// File: rtl/fuzzy_rule_pkg.sv
package fuzzy_rule_pkg;

    localparam int LBL_N = 7;
    localparam int LBL_W = 3;
    localparam int MID   = (LBL_N - 1) / 2;

    // Clamped-sum consequent table; rising selects the +s direction
    function automatic logic [LBL_N*LBL_N*LBL_W-1:0] build_rules(input bit rising);
        logic [LBL_N*LBL_N*LBL_W-1:0] tbl;
        int s;
        int v;
        tbl = '0;
        for (int i = 0; i < LBL_N; i++) begin
            for (int j = 0; j < LBL_N; j++) begin
                s = (i - MID) + (j - MID);
                v = rising ? MID + s : MID - s;
                if (v < 0) v = 0;
                if (v > LBL_N - 1) v = LBL_N - 1;
                tbl[(i*LBL_N+j)*LBL_W +: LBL_W] = LBL_W'(v);
            end
        end
        return tbl;
    endfunction

endpackage

// File: rtl/fuzzy_rule_terms.sv
module fuzzy_rule_terms #(
    parameter int N_LBL = 7,
    localparam int N_RULE = N_LBL * N_LBL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N_LBL-1:0]  err_lbl,
    input  logic [N_LBL-1:0]  rate_lbl,
    output logic [N_RULE-1:0] terms_q,
    output logic              pair_ok_q,
    output logic              valid_q
);

    logic [N_RULE-1:0] terms_d;

    // One AND gate per rule condition
    for (genvar i = 0; i < N_LBL; i++) begin : g_err
        for (genvar j = 0; j < N_LBL; j++) begin : g_rate
            assign terms_d[i*N_LBL+j] = err_lbl[i] & rate_lbl[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            terms_q   <= '0;
            pair_ok_q <= 1'b0;
            valid_q   <= 1'b0;
        end else begin
            terms_q   <= terms_d;
            pair_ok_q <= ($countones(err_lbl) == 1) && ($countones(rate_lbl) == 1);
            valid_q   <= in_valid;
        end
    end

endmodule

// File: rtl/fuzzy_rule_select.sv
module fuzzy_rule_select #(
    parameter int N_LBL = 7,
    parameter int CODE_W = 3,
    localparam int N_RULE = N_LBL * N_LBL,
    parameter logic [N_RULE*CODE_W-1:0] RULES = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_RULE-1:0] terms,
    input  logic              pair_ok,
    output logic [N_LBL-1:0]  lbl_q
);

    logic [N_LBL-1:0] hit;

    // OR every active rule into the label its consequent names
    always_comb begin
        hit = '0;
        for (int t = 0; t < N_RULE; t++) begin
            for (int k = 0; k < N_LBL; k++) begin
                if (terms[t] && (RULES[t*CODE_W +: CODE_W] == CODE_W'(k))) begin
                    hit[k] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lbl_q <= '0;
        end else begin
            lbl_q <= pair_ok ? hit : '0;
        end
    end

endmodule

// File: rtl/fuzzy_rule_table.sv
module fuzzy_rule_table #(
    parameter int N_LBL = fuzzy_rule_pkg::LBL_N,
    parameter int CODE_W = $clog2(N_LBL),
    localparam int N_RULE = N_LBL * N_LBL,
    parameter logic [N_RULE*CODE_W-1:0] LEFT_RULES  = fuzzy_rule_pkg::build_rules(1'b0),
    parameter logic [N_RULE*CODE_W-1:0] RIGHT_RULES = fuzzy_rule_pkg::build_rules(1'b1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [N_LBL-1:0] err_lbl,
    input  logic [N_LBL-1:0] rate_lbl,
    output logic             out_valid,
    output logic [N_LBL-1:0] left_lbl,
    output logic [N_LBL-1:0] right_lbl
);

    localparam int N_CH = 2;
    localparam logic [N_CH*N_RULE*CODE_W-1:0] ALL_RULES = {RIGHT_RULES, LEFT_RULES};

    logic [N_RULE-1:0]       terms_s1;
    logic                    pair_ok_s1;
    logic                    valid_s1;
    logic [N_LBL-1:0]        ch_lbl [N_CH];

    fuzzy_rule_terms #(.N_LBL(N_LBL)) u_terms (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .err_lbl   (err_lbl),
        .rate_lbl  (rate_lbl),
        .terms_q   (terms_s1),
        .pair_ok_q (pair_ok_s1),
        .valid_q   (valid_s1)
    );

    // One selector per motor channel, channel 0 left
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        fuzzy_rule_select #(
            .N_LBL  (N_LBL),
            .CODE_W (CODE_W),
            .RULES  (ALL_RULES[c*N_RULE*CODE_W +: N_RULE*CODE_W])
        ) u_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .terms   (terms_s1),
            .pair_ok (pair_ok_s1),
            .lbl_q   (ch_lbl[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= valid_s1;
        end
    end

    assign left_lbl  = ch_lbl[0];
    assign right_lbl = ch_lbl[1];

endmodule

// File: rtl/fuzzy_rule_table_chk.sv
module fuzzy_rule_table_chk #(
    parameter int N_LBL = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [N_LBL-1:0] err_lbl,
    input logic [N_LBL-1:0] rate_lbl,
    input logic             out_valid,
    input logic [N_LBL-1:0] left_lbl,
    input logic [N_LBL-1:0] right_lbl
);

    // Edges seen since reset release, saturating at the pipeline depth
    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && left_lbl == '0 && right_lbl == '0));

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R3 and R4: a clean one-hot pair must yield one label per channel
    assert_pair_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past($onehot(err_lbl), 2) && $past($onehot(rate_lbl), 2))
        |-> ($onehot(left_lbl) && $onehot(right_lbl)));

    assert_bad_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && !($past($onehot(err_lbl), 2) && $past($onehot(rate_lbl), 2)))
        |-> (left_lbl == '0 && right_lbl == '0));

    assert_single_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(left_lbl) && $onehot0(right_lbl));

endmodule

bind fuzzy_rule_table fuzzy_rule_table_chk #(.N_LBL(N_LBL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .err_lbl   (err_lbl),
    .rate_lbl  (rate_lbl),
    .out_valid (out_valid),
    .left_lbl  (left_lbl),
    .right_lbl (right_lbl)
);

// File: tb/fuzzy_rule_table_test.sv
`timescale 1ns/1ps
module fuzzy_rule_table_test;

    localparam int N = 7;

    typedef struct {
        logic         v;
        logic [N-1:0] l;
        logic [N-1:0] r;
        bit           ok;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [N-1:0] err_lbl = '0;
    logic [N-1:0] rate_lbl = '0;
    logic         out_valid;
    logic [N-1:0] left_lbl;
    logic [N-1:0] right_lbl;

    int tests = 0;
    int fails = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    fuzzy_rule_table uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .err_lbl   (err_lbl),
        .rate_lbl  (rate_lbl),
        .out_valid (out_valid),
        .left_lbl  (left_lbl),
        .right_lbl (right_lbl)
    );

    // R7 closed form: code = 3 -/+ s, clamped to 0..6
    function automatic int ref_code(int i, int j, bit right);
        int s;
        int c;
        s = (i - 3) + (j - 3);
        c = right ? 3 + s : 3 - s;
        if (c < 0) c = 0;
        if (c > 6) c = 6;
        return c;
    endfunction

    function automatic int first_bit(logic [N-1:0] x);
        for (int k = 0; k < N; k++) if (x[k]) return k;
        return 0;
    endfunction

    function automatic exp_t model(logic v, logic [N-1:0] e, logic [N-1:0] r);
        exp_t x;
        x.v  = v;
        x.ok = ($countones(e) == 1) && ($countones(r) == 1);
        x.l  = '0;
        x.r  = '0;
        if (x.ok) begin
            x.l[ref_code(first_bit(e), first_bit(r), 1'b0)] = 1'b1;
            x.r[ref_code(first_bit(e), first_bit(r), 1'b1)] = 1'b1;
        end
        return x;
    endfunction

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle: compare the result due now, then drive a new pair (R8 streaming)
    task automatic step(logic v, logic [N-1:0] e, logic [N-1:0] r);
        exp_t x;
        @(negedge clk);
        if (q.size() == 2) begin
            x = q.pop_front();
            check("R2 out_valid", {6'b0, out_valid}, {6'b0, x.v});
            check(x.ok ? "R3 R7 left_lbl" : "R5 left_lbl", left_lbl, x.l);
            check(x.ok ? "R4 R7 right_lbl" : "R5 right_lbl", right_lbl, x.r);
            tests++;
            if ($countones(left_lbl) > 1 || $countones(right_lbl) > 1) begin
                fails++;
                $display("FAIL R6 actual=%b/%b expected=at most one bit", left_lbl, right_lbl);
            end
        end
        in_valid = v;
        err_lbl  = e;
        rate_lbl = r;
        q.push_back(model(v, e, r));
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        in_valid = 1'b1;
        err_lbl  = 7'b0001000;
        rate_lbl = 7'b0001000;
        repeat (3) @(negedge clk);
        check("R1 out_valid", {6'b0, out_valid}, 7'b0);
        check("R1 left_lbl", left_lbl, '0);
        check("R1 right_lbl", right_lbl, '0);
        rst_n = 1'b1;

        // every one-hot pair, back to back (R3 R4 R7)
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                step(1'b1, 7'(1 << i), 7'(1 << j));
        // valid toggling with the labels still followed (R2 R8)
        for (int k = 0; k < 14; k++)
            step(k[0], 7'(1 << (k % N)), 7'(1 << ((k * 3) % N)));
        // malformed inputs (R5)
        step(1'b1, 7'b0000000, 7'b0001000);
        step(1'b1, 7'b0001000, 7'b0000000);
        step(1'b1, 7'b0011000, 7'b0001000);
        step(1'b0, 7'b0001000, 7'b1000001);
        step(1'b1, 7'b1111111, 7'b1111111);
        step(1'b1, 7'b0000001, 7'b1000000);
        step(1'b1, 7'b0000000, 7'b0000000);
        step(1'b1, 7'b1000000, 7'b1000000);
        // drain
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule